// File: doc/BRIEF.md
# Bit-Addressable Control Latch Port

This block holds an 8-bit system control word behind one I/O port in a 16-bit I/O address space with an 8-bit data path. Software never writes the whole word. Each write names one bit with a 3-bit select code in the low bits of the data byte. It gives that bit its new value through data bit 3, which is active low: 0 sets the bit and 1 clears it. Five select codes are wired to real control bits. The other three codes change nothing.

A read on the same port returns the whole control word and changes nothing. Each implemented bit also drives its own output pin, so downstream logic can use it without decoding the word. Those outputs are interrupt enable, boot ROM select, startup ROM select, bus override and auxiliary PROM enable. A synchronous active-low reset clears the word.

Top module: `ctl_latch_port`

## Requirements
- R1: After a clock edge with `rst_n` low, the control word is 0x00 and all five control outputs are 0.
- R2: A write (`io_wr` high, `io_addr` equal to `BASE_ADDR`) with `io_wdata[3]` = 0 and select code `io_wdata[2:0]` in {0,1,2,4,5} sets word bit number equal to the code on the next clock edge.
- R3: The same write with `io_wdata[3]` = 1 clears the selected bit on the next clock edge.
- R4: A write changes only the selected bit. All other bits keep their value, and `io_wdata[7:4]` has no effect.
- R5: Select codes 3, 6 and 7 leave the whole word unchanged.
- R6: A write strobe whose address differs from `BASE_ADDR` leaves the word unchanged. Data presented with `io_wr` low also leaves the word unchanged.
- R7: While `io_rd` is high and `io_addr` equals `BASE_ADDR`, `io_rdata` shows the whole word in the same cycle. At all other times `io_rdata` is 0x00. A read never changes the word.
- R8: Word bits 3, 6 and 7 always read as 0.
- R9: The outputs mirror the word: `aux_prom_en` is bit 0, `bus_override` is bit 1, `startup_rom_sel` is bit 2, `boot_rom_sel` is bit 4 and `irq_en` is bit 5.
- R10: A write presented while `rst_n` is low is lost, and the word stays 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| io_addr | input | 16 | I/O port address |
| io_wr | input | 1 | Write strobe |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 8 | Write data: select code and inverted data bit |
| io_rdata | output | 8 | Read data: control word, or 0 when not read |
| aux_prom_en | output | 1 | Auxiliary PROM enable (bit 0) |
| bus_override | output | 1 | Bus override (bit 1) |
| startup_rom_sel | output | 1 | Startup ROM select (bit 2) |
| boot_rom_sel | output | 1 | Boot ROM select (bit 4) |
| irq_en | output | 1 | Interrupt enable (bit 5) |

## Verification
Directed writes walk each live select code through set and then clear. This shows that the code-to-bit mapping is correct and that the data bit is inverted. Writes using the dead codes 3, 6 and 7, writes to a wrong address and data with no strobe are each followed by a readback. The readback shows that none of them disturbed the word. A seeded random mix of codes, data values, upper-nibble junk and near-miss addresses is compared against a bench model after every step. This separates single-bit updates from whole-byte corruption. A write held during reset separates reset priority from write priority.

// File: rtl/ctl_latch_pkg.sv
// Package: shared sizes and the map of which latch bits exist.
// Assumes an 8-bit data path and a 3-bit select code.
package ctl_latch_pkg;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 16;
    localparam int SEL_W  = 3;
    localparam int NBITS  = 1 << SEL_W;
    // Bits that a select code can reach; the rest stay zero.
    localparam logic [NBITS-1:0] LATCH_IMPL = 8'b0011_0111;
    // Position of the active-low data bit in a written byte.
    localparam int DBIT_POS = 3;

    typedef enum logic [SEL_W-1:0] {
        SEL_AUX_PROM = 3'd0,
        SEL_BUS_OVR  = 3'd1,
        SEL_STARTUP  = 3'd2,
        SEL_SPARE3   = 3'd3,
        SEL_BOOT     = 3'd4,
        SEL_IRQ      = 3'd5,
        SEL_SPARE6   = 3'd6,
        SEL_SPARE7   = 3'd7
    } sel_code_e;
endpackage

// File: rtl/ctl_port_decode.sv
// Module: decodes address and strobes into write/read hits and splits
// the written byte into select code and set/clear command.
// Assumes strobes are single-cycle-sampled levels, synchronous to clk.
module ctl_port_decode
    import ctl_latch_pkg::*;
#(
    parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h00FF
) (
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic [DATA_W-1:0] io_wdata,
    output logic              wr_hit,
    output logic              rd_hit,
    output sel_code_e         sel,
    output logic              set_val
);
    logic addr_match;

    // Purpose: compare the port address and qualify the strobes.
    always_comb begin
        addr_match = (io_addr == BASE_ADDR);
        wr_hit     = addr_match && io_wr;
        rd_hit     = addr_match && io_rd;
    end

    // Purpose: extract the select code and invert the data bit.
    always_comb begin
        sel     = sel_code_e'(io_wdata[SEL_W-1:0]);
        set_val = ~io_wdata[DBIT_POS];
    end
endmodule

// File: rtl/ctl_latch_cell.sv
// Module: one addressable latch bit; loads set_val when a write hits
// and the select code names this bit. Assumes synchronous active-low reset.
module ctl_latch_cell
    import ctl_latch_pkg::*;
#(
    parameter int BIT_IDX = 0
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wr_hit,
    input  sel_code_e sel,
    input  logic      set_val,
    output logic      q
);
    logic hit_me;

    // Purpose: detect a write aimed at this bit.
    always_comb hit_me = wr_hit && (sel == sel_code_e'(BIT_IDX));

    // Purpose: hold the bit; reset wins over a write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= 1'b0;
        else if (hit_me)
            q <= set_val;
    end

    // R2: a targeted write with data bit low sets the bit.
    a_r2_set_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && sel == sel_code_e'(BIT_IDX) && set_val) |=> q);
    // R3: a targeted write with data bit high clears the bit.
    a_r3_clear_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && sel == sel_code_e'(BIT_IDX) && !set_val) |=> !q);
    // R4: writes aimed elsewhere leave this bit alone.
    a_r4_hold_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !(wr_hit && sel == sel_code_e'(BIT_IDX))) |=> $stable(q));
endmodule

// File: rtl/ctl_readback.sv
// Module: gates the control word onto the read bus during a read hit.
// Assumes a combinational read path; drives 0 when not selected.
module ctl_readback
    import ctl_latch_pkg::*;
(
    input  logic              rd_hit,
    input  logic [DATA_W-1:0] word,
    output logic [DATA_W-1:0] rdata
);
    // Purpose: drive the word only while the port is read.
    always_comb rdata = rd_hit ? word : '0;
endmodule

// File: rtl/ctl_latch_port.sv
// Module: top of the bit-addressable control latch port. Builds one
// latch cell per implemented bit, ties the rest to zero, and fans the
// word out to readback and the dedicated control pins.
// Assumes one clock domain and a synchronous active-low reset.
module ctl_latch_port
    import ctl_latch_pkg::*;
#(
    parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h00FF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic [DATA_W-1:0] io_wdata,
    output logic [DATA_W-1:0] io_rdata,
    output logic              aux_prom_en,
    output logic              bus_override,
    output logic              startup_rom_sel,
    output logic              boot_rom_sel,
    output logic              irq_en
);
    logic            wr_hit;
    logic            rd_hit;
    sel_code_e       sel;
    logic            set_val;
    logic [NBITS-1:0] word;

    ctl_port_decode #(.BASE_ADDR(BASE_ADDR)) u_dec (
        .io_addr (io_addr),
        .io_wr   (io_wr),
        .io_rd   (io_rd),
        .io_wdata(io_wdata),
        .wr_hit  (wr_hit),
        .rd_hit  (rd_hit),
        .sel     (sel),
        .set_val (set_val)
    );

    // Purpose: one cell per reachable bit, constant zero elsewhere.
    for (genvar i = 0; i < NBITS; i++) begin : g_bit
        if (LATCH_IMPL[i]) begin : g_cell
            ctl_latch_cell #(.BIT_IDX(i)) u_cell (
                .clk    (clk),
                .rst_n  (rst_n),
                .wr_hit (wr_hit),
                .sel    (sel),
                .set_val(set_val),
                .q      (word[i])
            );
        end else begin : g_tie
            assign word[i] = 1'b0;
        end
    end

    ctl_readback u_rb (
        .rd_hit(rd_hit),
        .word  (word),
        .rdata (io_rdata)
    );

    // Purpose: drive the dedicated control pins from the word.
    always_comb begin
        aux_prom_en     = word[SEL_AUX_PROM];
        bus_override    = word[SEL_BUS_OVR];
        startup_rom_sel = word[SEL_STARTUP];
        boot_rom_sel    = word[SEL_BOOT];
        irq_en          = word[SEL_IRQ];
    end

    // R7: a read hit shows the pins and bits as one consistent byte.
    a_r7_readback: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && io_addr == BASE_ADDR) |->
        (io_rdata == {2'b00, irq_en, boot_rom_sel, 1'b0,
                      startup_rom_sel, bus_override, aux_prom_en}));
    // R7: the read bus is quiet when the port is not read.
    a_r7_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !(io_rd && io_addr == BASE_ADDR) |-> (io_rdata == '0));
    // R5: a write using a dead code leaves the pins unchanged.
    a_r5_dead_code: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && io_wr && (io_wdata[2:0] == 3'd3 || io_wdata[2:0] >= 3'd6))
        |=> $stable({irq_en, boot_rom_sel, startup_rom_sel, bus_override, aux_prom_en}));
endmodule

// File: tb/sim_ctl_latch_port.sv
module sim_ctl_latch_port;
    localparam logic [15:0] BASE = 16'h00FF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] io_addr = '0;
    logic        io_wr = 1'b0;
    logic        io_rd = 1'b0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  io_rdata;
    logic        aux_prom_en, bus_override, startup_rom_sel, boot_rom_sel, irq_en;

    int n_cmp = 0;
    int n_bad = 0;
    logic [7:0] model = '0;
    bit done = 0;

    always #10 clk = ~clk;

    ctl_latch_port #(.BASE_ADDR(BASE)) u0 (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr),
        .io_rd(io_rd), .io_wdata(io_wdata), .io_rdata(io_rdata),
        .aux_prom_en(aux_prom_en), .bus_override(bus_override),
        .startup_rom_sel(startup_rom_sel), .boot_rom_sel(boot_rom_sel),
        .irq_en(irq_en)
    );

    // Expected word after a write, from R2-R5.
    function automatic logic [7:0] apply_wr(logic [7:0] cur, logic [7:0] d);
        logic [7:0] nxt = cur;
        if (d[2:0] inside {3'd0, 3'd1, 3'd2, 3'd4, 3'd5})
            nxt[d[2:0]] = ~d[3];
        return nxt;
    endfunction

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic wr(logic [15:0] a, logic [7:0] d, logic strobe);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = strobe;
        @(negedge clk);
        io_wr = 1'b0;
        if (strobe && a == BASE) model = apply_wr(model, d);
    endtask

    // Read the port and compare word, pins (R9) and fixed-zero bits (R8).
    task automatic rd(string req);
        @(negedge clk);
        io_addr = BASE; io_rd = 1'b1;
        #1;
        check(req, io_rdata, model);
        check("R8", io_rdata & 8'hC8, 8'h00);
        check("R9", {2'b00, irq_en, boot_rom_sel, 1'b0, startup_rom_sel,
                     bus_override, aux_prom_en}, model);
        io_rd = 1'b0;
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_bad++; n_cmp++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        // R10: write held during reset is lost.
        io_addr = BASE; io_wdata = 8'h05; io_wr = 1'b1;
        repeat (3) @(negedge clk);
        io_wr = 1'b0;
        #1;
        check("R1", {2'b00, irq_en, boot_rom_sel, 1'b0, startup_rom_sel,
                     bus_override, aux_prom_en}, 8'h00);
        rst_n = 1'b1;
        rd("R10");
        // R7: idle read bus is zero.
        @(negedge clk); io_addr = BASE; io_rd = 1'b0; #1;
        check("R7", io_rdata, 8'h00);
        // R2/R3: walk every live code through set and clear.
        for (int c = 0; c < 8; c++) begin
            wr(BASE, 8'(c), 1'b1);          rd(c == 3 || c > 5 ? "R5" : "R2");
            wr(BASE, 8'(c) | 8'h08, 1'b1);  rd(c == 3 || c > 5 ? "R5" : "R3");
        end
        // R4: build a pattern and flip one bit with junk in the upper nibble.
        wr(BASE, 8'h00, 1'b1); wr(BASE, 8'h04, 1'b1); wr(BASE, 8'h05, 1'b1);
        wr(BASE, 8'hF1, 1'b1);
        rd("R4");
        // R5: dead codes with both data values.
        wr(BASE, 8'h03, 1'b1); wr(BASE, 8'h0E, 1'b1); wr(BASE, 8'h07, 1'b1);
        rd("R5");
        // R6: wrong address and missing strobe.
        wr(BASE ^ 16'h0100, 8'h0D, 1'b1); wr(16'h00FE, 8'h08, 1'b1);
        wr(BASE, 8'h0C, 1'b0);
        rd("R6");
        // R7: wrong-address read gives zero, repeated reads change nothing.
        @(negedge clk); io_addr = 16'h00FE; io_rd = 1'b1; #1;
        check("R7", io_rdata, 8'h00);
        io_rd = 1'b0;
        rd("R7"); rd("R7");
        // Random mix.
        for (int k = 0; k < 400; k++) begin
            logic [15:0] a = ($urandom % 4 == 0) ? (BASE ^ 16'(1 << ($urandom % 16))) : BASE;
            wr(a, 8'($urandom), 1'($urandom % 8 != 0));
            rd("R4");
        end
        // R1: reset clears a non-zero word.
        wr(BASE, 8'h05, 1'b1);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1; model = '0;
        rd("R1");
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule